// File: doc/BRIEF.md
# UART Receive Buffer with Line Status

This block sits between a UART deserializer and a register-read port. Each time the deserializer finishes a character it raises a one-cycle valid strobe carrying the eight data bits and three error tags: a parity error, a framing error and a break. The block stores the character and its tags together in a first-in first-out buffer. The buffer holds 16 entries by default, and the depth is a parameter. It presents the character at the head of the buffer on a data output, along with five line-status flags: data ready, overrun, parity, framing and break.

A one-cycle data-read strobe consumes the head character. A one-cycle status-read strobe clears the sticky error flags. The tags of a character are not reported when it arrives. They are reported when that character becomes the head, so software always sees the error bits that belong to the character it is about to read. If a character arrives while the buffer is full, the new character is dropped, the stored contents stay untouched and overrun is flagged.

All strobes are sampled on the rising clock edge. The outputs are registered and show the result of a strobe from the cycle after it.

Top module: `rxLineFifo`

## Requirements
- R1: After reset, headData and all five status flags are 0.
- R2: stDataReady is 1 in a cycle exactly when the buffer holds at least one unread character. It returns to 0 in the cycle after the last character is consumed.
- R3: Characters leave in arrival order. Up to DEPTH (16) characters are held. headData shows the head character from the cycle after it became the head.
- R4: A chrValid strobe that arrives while DEPTH characters are held is dropped. The count is checked before any same-cycle read. stOverrun is set in the next cycle, and the stored characters are unchanged.
- R5: A statRd strobe clears stOverrun, stParity, stFraming and stBreak in the next cycle, unless a set happens in that same cycle.
- R6: stParity, stFraming and stBreak take the tags of a character when it becomes the head. This happens when it is written into an empty buffer, or when a data read advances the head onto it. A character queued behind the head does not affect the flags.
- R7: Once set, an error flag stays set through further data reads until a status read.
- R8: If a flag is set by a head-tag load or by an overrun in the same cycle as a statRd, the flag is 1 in the next cycle.
- R9: A dataRd while the buffer is empty changes nothing. headData keeps its last value, stDataReady stays 0, and the next character written is the next one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| chrValid | input | 1 | One-cycle strobe: a received character is offered |
| chrData | input | 8 | Received character |
| chrParErr | input | 1 | Parity-error tag of the offered character |
| chrFrmErr | input | 1 | Framing-error tag of the offered character |
| chrBrk | input | 1 | Break tag of the offered character |
| dataRd | input | 1 | Data-register read strobe; consumes the head character |
| statRd | input | 1 | Status-register read strobe; clears the error flags |
| headData | output | 8 | Character at the buffer head (last head when empty) |
| stDataReady | output | 1 | At least one unread character is held |
| stOverrun | output | 1 | Sticky: a character was dropped on a full buffer |
| stParity | output | 1 | Sticky: parity-error tag of a head character |
| stFraming | output | 1 | Sticky: framing-error tag of a head character |
| stBreak | output | 1 | Sticky: break tag of a head character |

## Verification
If the occupancy count drifts from the pointers, stDataReady gets the wrong value, or headData repeats or skips a character, on the very next read. A pointer that wraps wrongly only shows up once the buffer has cycled past its depth, so the stimulus fills and drains the buffer many times. A head-tag load taken from the wrong slot shows up one cycle after the head advances, as an error flag that belongs to a neighbouring character. A wrong priority between clear and set shows up only when a status read lands on a load cycle, so that coincidence is driven on purpose as well as at random.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;

  localparam int CHAR_W = 8;

  // One stored character together with its error tags (11 bits)
  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rxEntry_t;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic wrEn;      // store the offered character at the tail
    logic popEn;     // advance the head pointer
    logic loadIn;    // the offered character becomes the head
    logic loadNext;  // the entry behind the head becomes the head
    logic ovrSet;    // a character was dropped on a full buffer
    logic clrStat;   // status read: clear the sticky flags
  } fifoCtl_t;

endpackage

// File: rtl/rxfifoCtl.sv
module rxfifoCtl
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     chrValid,
  input  logic     dataRd,
  input  logic     statRd,
  output fifoCtl_t ctl,
  output logic     dataReady
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic             isFull;
  logic             isEmpty;

  assign isFull  = (cntQ == FULL_CNT);
  assign isEmpty = (cntQ == '0);

  always_comb begin
    ctl          = '0;
    ctl.wrEn     = chrValid && !isFull;
    ctl.popEn    = dataRd && !isEmpty;
    ctl.ovrSet   = chrValid && isFull;
    ctl.clrStat  = statRd;
    // A new head appears from the input when the buffer is empty, or when
    // its only entry is consumed while a new character is written.
    ctl.loadIn   = ctl.wrEn && (isEmpty || (ctl.popEn && cntQ == ONE_CNT));
    ctl.loadNext = ctl.popEn && (cntQ > ONE_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + CNT_W'(ctl.wrEn) - CNT_W'(ctl.popEn);
    end
  end

  assign dataReady = !isEmpty;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FULL_CNT);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && chrValid && !dataRd) |=> (cntQ == FULL_CNT));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && dataRd && !chrValid) |=> (cntQ == '0));

endmodule

// File: rtl/rxfifoData.sv
module rxfifoData
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [CHAR_W-1:0] chrData,
  input  logic              chrParErr,
  input  logic              chrFrmErr,
  input  logic              chrBrk,
  output logic [CHAR_W-1:0] headData,
  output logic              stOverrun,
  output logic              stParity,
  output logic              stFraming,
  output logic              stBreak
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  rxEntry_t          slotQ [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  rxEntry_t          inEntry;
  rxEntry_t          nextEntry;
  rxEntry_t          loadEntry;
  logic              loadAny;
  logic [CHAR_W-1:0] headQ;
  logic              ovrQ;
  logic              parQ;
  logic              frmQ;
  logic              brkQ;

  assign inEntry   = '{brk: chrBrk, frm: chrFrmErr, par: chrParErr, data: chrData};
  assign nextEntry = slotQ[bump(rdPtr)];
  assign loadAny   = ctl.loadIn || ctl.loadNext;
  assign loadEntry = ctl.loadIn ? inEntry : nextEntry;

  // Storage slots, one register row per entry
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[g] <= '0;
      end else if (ctl.wrEn && wrPtr == PTR_W'(g)) begin
        slotQ[g] <= inEntry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.wrEn)  wrPtr <= bump(wrPtr);
      if (ctl.popEn) rdPtr <= bump(rdPtr);
    end
  end

  // Head character and sticky status; a set in the same cycle beats a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      ovrQ  <= 1'b0;
      parQ  <= 1'b0;
      frmQ  <= 1'b0;
      brkQ  <= 1'b0;
    end else begin
      if (loadAny) headQ <= loadEntry.data;
      ovrQ <= (ovrQ && !ctl.clrStat) || ctl.ovrSet;
      parQ <= (parQ && !ctl.clrStat) || (loadAny && loadEntry.par);
      frmQ <= (frmQ && !ctl.clrStat) || (loadAny && loadEntry.frm);
      brkQ <= (brkQ && !ctl.clrStat) || (loadAny && loadEntry.brk);
    end
  end

  assign headData  = headQ;
  assign stOverrun = ovrQ;
  assign stParity  = parQ;
  assign stFraming = frmQ;
  assign stBreak   = brkQ;

  // R4
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ovrSet |=> ovrQ);

  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrStat && !loadAny && !ctl.ovrSet) |=> !(ovrQ || parQ || frmQ || brkQ));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((parQ || frmQ || brkQ) && !ctl.clrStat) |=> (parQ || frmQ || brkQ));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrStat && ctl.loadIn && chrParErr) |=> parQ);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadAny |=> $stable(headQ));

endmodule

// File: rtl/rxLineFifo.sv
module rxLineFifo
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chrValid,
  input  logic [7:0] chrData,
  input  logic       chrParErr,
  input  logic       chrFrmErr,
  input  logic       chrBrk,
  input  logic       dataRd,
  input  logic       statRd,
  output logic [7:0] headData,
  output logic       stDataReady,
  output logic       stOverrun,
  output logic       stParity,
  output logic       stFraming,
  output logic       stBreak
);

  fifoCtl_t ctl;

  rxfifoCtl #(.DEPTH(DEPTH)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .chrValid  (chrValid),
    .dataRd    (dataRd),
    .statRd    (statRd),
    .ctl       (ctl),
    .dataReady (stDataReady)
  );

  rxfifoData #(.DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .chrData   (chrData),
    .chrParErr (chrParErr),
    .chrFrmErr (chrFrmErr),
    .chrBrk    (chrBrk),
    .headData  (headData),
    .stOverrun (stOverrun),
    .stParity  (stParity),
    .stFraming (stFraming),
    .stBreak   (stBreak)
  );

endmodule

// File: tb/rxLineFifo_test.sv
module rxLineFifo_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chrValid = 1'b0;
  logic [7:0] chrData = '0;
  logic       chrParErr = 1'b0;
  logic       chrFrmErr = 1'b0;
  logic       chrBrk = 1'b0;
  logic       dataRd = 1'b0;
  logic       statRd = 1'b0;
  logic [7:0] headData;
  logic       stDataReady, stOverrun, stParity, stFraming, stBreak;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Bench model: queue of {brk, frm, par, data}
  logic [10:0] q[$];
  logic [7:0]  expHead = '0;
  logic        expOvr = 0, expPar = 0, expFrm = 0, expBrk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxLineFifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData),
    .chrParErr(chrParErr), .chrFrmErr(chrFrmErr), .chrBrk(chrBrk),
    .dataRd(dataRd), .statRd(statRd), .headData(headData),
    .stDataReady(stDataReady), .stOverrun(stOverrun), .stParity(stParity),
    .stFraming(stFraming), .stBreak(stBreak)
  );

  function automatic logic nextFlag(input logic cur, input logic clr, input logic set);
    return (cur && !clr) || set;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected next state from the requirements (R2..R9)
  task automatic modelStep(input logic v, input logic [10:0] ent,
                           input logic rd, input logic sr);
    int  cnt  = q.size();
    bit  wr   = v && (cnt < DEPTH);
    bit  pop  = rd && (cnt > 0);
    bit  ovr  = v && (cnt == DEPTH);
    bit  load = 1'b0;
    logic [10:0] nh = '0;
    if (cnt == 0 && wr) begin load = 1; nh = ent; end
    else if (pop && cnt >= 2) begin load = 1; nh = q[1]; end
    else if (pop && cnt == 1 && wr) begin load = 1; nh = ent; end
    if (pop) void'(q.pop_front());
    if (wr) q.push_back(ent);
    expOvr = nextFlag(expOvr, sr, ovr);
    expPar = nextFlag(expPar, sr, load && nh[8]);
    expFrm = nextFlag(expFrm, sr, load && nh[9]);
    expBrk = nextFlag(expBrk, sr, load && nh[10]);
    if (load) expHead = nh[7:0];
  endtask

  task automatic compareAll();
    chk("R3 headData", 32'(headData), 32'(expHead));
    chk("R2 stDataReady", 32'(stDataReady), 32'(q.size() != 0));
    chk("R4 stOverrun", 32'(stOverrun), 32'(expOvr));
    chk("R6 stParity", 32'(stParity), 32'(expPar));
    chk("R6 stFraming", 32'(stFraming), 32'(expFrm));
    chk("R6 stBreak", 32'(stBreak), 32'(expBrk));
  endtask

  // Called at a falling edge; drives one cycle and checks after the edge
  task automatic cyc(input logic v, input logic [7:0] d, input logic p,
                     input logic f, input logic b, input logic rd, input logic sr);
    chrValid = v; chrData = d; chrParErr = p; chrFrmErr = f; chrBrk = b;
    dataRd = rd; statRd = sr;
    modelStep(v, {b, f, p, d}, rd, sr);
    @(posedge clk);
    @(negedge clk);
    chrValid = 0; dataRd = 0; statRd = 0;
    chrParErr = 0; chrFrmErr = 0; chrBrk = 0;
    compareAll();
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 headData", 32'(headData), 0);
    chk("R1 ready", 32'(stDataReady), 0);
    chk("R1 overrun", 32'(stOverrun), 0);
    chk("R1 parity", 32'(stParity), 0);
    chk("R1 framing", 32'(stFraming), 0);
    chk("R1 break", 32'(stBreak), 0);

    // R6: write into empty with parity tag -> reported at once
    cyc(1, 8'hA5, 1, 0, 0, 0, 0);
    chk("R6 parity on new head", 32'(stParity), 1);
    chk("R3 head A5", 32'(headData), 32'h0A5);
    // R6: char behind head does not report its framing tag
    cyc(1, 8'h3C, 0, 1, 0, 0, 0);
    chk("R6 framing behind head", 32'(stFraming), 0);
    // R5: status read clears
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R5 parity cleared", 32'(stParity), 0);
    chk("R2 still ready", 32'(stDataReady), 1);
    // R6: head advances onto 3C
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R6 framing loaded", 32'(stFraming), 1);
    chk("R3 head 3C", 32'(headData), 32'h03C);
    // R7: further read keeps the flag
    cyc(1, 8'h11, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R7 framing sticky", 32'(stFraming), 1);
    // R8: load of break tag beats simultaneous clear
    cyc(1, 8'h22, 0, 0, 1, 0, 0);
    cyc(1, 8'h33, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1);
    chk("R8 break wins over clear", 32'(stBreak), 1);
    chk("R5 framing cleared", 32'(stFraming), 0);
    // drain and read empty (R9)
    while (q.size() != 0) cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R9 head kept", 32'(headData), 32'h033);
    chk("R9 not ready", 32'(stDataReady), 0);
    cyc(1, 8'h77, 0, 0, 0, 0, 1);
    chk("R9 next write read", 32'(headData), 32'h077);
    cyc(0, 0, 0, 0, 0, 1, 0);

    // R4: fill to depth, overflow with concurrent read, then drain in order
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h40 + i), 0, 0, 0, 0, 0);
    cyc(1, 8'hEE, 1, 1, 1, 1, 0);
    chk("R4 overrun set", 32'(stOverrun), 1);
    chk("R4 one read left fifteen", 32'(q.size()), 15);
    cyc(1, 8'hEF, 0, 0, 0, 0, 1);
    chk("R4 write after read space", 32'(stOverrun), 0);
    cyc(1, 8'hF0, 0, 0, 0, 0, 1);
    chk("R8 overrun wins over clear", 32'(stOverrun), 1);
    while (q.size() != 0) cyc(0, 0, 0, 0, 0, 1, 0);

    // Constrained random: alternate fill-biased and drain-biased phases
    for (int ph = 0; ph < 12; ph++) begin
      int rdPct = (ph % 2 == 0) ? 15 : 75;
      for (int n = 0; n < 250; n++) begin
        logic v  = ($urandom % 100) < 55;
        logic rd = ($urandom % 100) < rdPct;
        logic sr = ($urandom % 100) < 12;
        logic p  = ($urandom % 100) < 20;
        logic f  = ($urandom % 100) < 20;
        logic b  = ($urandom % 100) < 10;
        cyc(v, 8'($urandom), p, f, b, rd, sr);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule